// File: doc/BRIEF.md
# MSI Doorbell Frame

This block turns a message-signalled interrupt into a wire interrupt. A bus master writes a doorbell, and the frame converts that write into an interrupt number. If the number falls inside the block's window of shared peripheral interrupts, the frame raises a single-cycle, rising-edge pulse on the matching output line. The interrupt controller that receives these lines treats each one as edge-triggered.

The window is fixed at elaboration by two parameters: a base number and a count. A read-only descriptor register reports both values, and an identification register returns a parameter code. A third parameter picks one of three ways to decode the interrupt number:
- **Absolute:** the write data is the interrupt number.
- **Offset:** the write data is an index added to an offset. The offset is either the window base or the constant 32.
- **Address-encoded:** the data is ignored and the number comes from the write address, as 32 plus the address divided by eight.

A doorbell whose number misses the window is dropped. It also sets a sticky fault bit, which can be read back.

Top module: `msi_doorbell_frame`

## Requirements
- R1: After reset, all interrupt outputs are low, `ready` is low, and the fault bit reads 0.
- R2: A read at offset 0x008 returns the window base in bits [25:16] and the count in bits [9:0]. All other bits read as zero.
- R3: A read at offset 0xFCC returns the `ID_CODE` parameter. A read at offset 0x010 returns the sticky fault bit in bit 0, with zeros above it.
- R4: In absolute mode (`MODE`=0), a write to offset 0x040 carries an interrupt number n in its data, compared over all 32 bits. If n is inside the window, output bit (n − base) is high for exactly the one cycle after the write.
- R5: In offset mode (`MODE`=1), the interrupt number is the offset plus the data. The offset is 32 when `FIXED_OFS`=1 and the window base when `FIXED_OFS`=0. The pulse then follows the same rule as in R4.
- R6: In address mode (`MODE`=2), a write to an address whose bits [2:0] are zero selects interrupt number 32 + addr[ADDR_W-1:3], whatever the data. A write to an address whose low three bits are not zero has no effect.
- R7: A doorbell whose number lies outside [base, base+count−1] produces no pulse and sets the fault bit. Once set, the fault bit stays set until reset.
- R8: Writes on consecutive cycles to the same interrupt each produce one cycle of high on that bit, so the bit stays high for as many cycles as there were writes.
- R9: Reads of unmapped offsets return zero. In absolute and offset modes, writes to the descriptor, identification and fault offsets change nothing and raise no pulse.
- R10: `ready` is high for exactly the cycle after each read or write strobe, and `rdata` holds the read result in that cycle.
- R11: At most one interrupt output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | ADDR_W | Byte offset within the frame |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while `ready` is high |
| ready | output | 1 | Access acknowledge, the cycle after a strobe |
| irq_out | output | NUM_SPI | Edge pulses; bit i is interrupt base+i |

## Verification
Two events can share a cycle: a doorbell that misses the window sets the fault bit, and a later read of the fault offset returns that bit. The bench provokes this by reading the fault bit right after rejected writes in each mode. It judges the result by requiring no pulse at the write and a 1 in the read data.

Back-to-back doorbells to one line also overlap, because each new write lands while the previous pulse is still on the output. The bench issues two writes on consecutive cycles to the same line and requires that bit high in both following cycles and low in the cycle after.

// File: rtl/msi_doorbell_frame.sv
module msi_doorbell_frame #(
  parameter int          BASE_SPI  = 64,
  parameter int          NUM_SPI   = 16,
  parameter int          MODE      = 0,
  parameter int          FIXED_OFS = 0,
  parameter logic [31:0] ID_CODE   = 32'h0002_1C3B,
  parameter int          ADDR_W    = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic               ready,
  output logic [NUM_SPI-1:0] irq_out
);

  localparam int IDX_W    = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1;
  localparam int OFS_VAL  = (FIXED_OFS != 0) ? 32 : BASE_SPI;
  localparam int LAST_SPI = BASE_SPI + NUM_SPI - 1;
  localparam int DESC_OFS = 'h008;
  localparam int FLT_OFS  = 'h010;
  localparam int BELL_OFS = 'h040;
  localparam int ID_OFS   = 'hFCC;
  localparam logic [31:0] DESC_VAL = {6'd0, 10'(BASE_SPI), 6'd0, 10'(NUM_SPI)};

  initial begin
    assert (BASE_SPI >= 32 && NUM_SPI > 0 && BASE_SPI + NUM_SPI <= 1019)
      else $error("spi window parameters out of range");
  end

  logic [32:0]        spi_num;
  logic               bell_hit, in_range, fire, miss;
  logic [IDX_W-1:0]   idx;
  logic [NUM_SPI-1:0] irq_q;
  logic               fault_q, ready_q;
  logic [31:0]        rdata_q, rd_mux;

  always_comb begin
    case (MODE)
      0:       spi_num = {1'b0, wdata};
      1:       spi_num = 33'(OFS_VAL) + {1'b0, wdata};
      default: spi_num = 33'(32) + 33'(addr[ADDR_W-1:3]);
    endcase
  end

  assign bell_hit = wr_en && ((MODE == 2) ? (addr[2:0] == 3'd0)
                                          : (addr == ADDR_W'(BELL_OFS)));
  assign in_range = (spi_num >= 33'(BASE_SPI)) && (spi_num <= 33'(LAST_SPI));
  assign fire     = bell_hit && in_range;
  assign miss     = bell_hit && !in_range;
  assign idx      = IDX_W'(spi_num - 33'(BASE_SPI));

  always_comb begin
    if (addr == ADDR_W'(DESC_OFS))     rd_mux = DESC_VAL;
    else if (addr == ADDR_W'(ID_OFS))  rd_mux = ID_CODE;
    else if (addr == ADDR_W'(FLT_OFS)) rd_mux = {31'd0, fault_q};
    else                               rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q   <= '0;
      fault_q <= 1'b0;
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      irq_q   <= fire ? (NUM_SPI'(1) << idx) : '0;
      fault_q <= fault_q | miss;
      ready_q <= wr_en | rd_en;
      rdata_q <= rd_en ? rd_mux : '0;
    end
  end

  assign irq_out = irq_q;
  assign ready   = ready_q;
  assign rdata   = rdata_q;

  p_one_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_out));

  p_pulse_on_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ($countones(irq_out) == 1));

  p_quiet_on_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> (irq_out == '0));

  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> fault_q);

  p_fault_rises_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(miss));

  p_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |=> ready);

  p_no_spurious_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en || rd_en) |=> !ready);

endmodule

// File: tb/tb_msi_doorbell_frame.sv
module tb_msi_doorbell_frame;
  localparam int BASE = 64;
  localparam int NUM  = 16;
  localparam logic [31:0] IDV = 32'h1234_5678;

  logic clk = 0, rst_n = 0;
  logic wr_a = 0, wr_o = 0, wr_x = 0, rd_en = 0;
  logic [12:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_a, rd_o, rd_x;
  logic rdy_a, rdy_o, rdy_x;
  logic [NUM-1:0] irq_a, irq_o, irq_x;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  msi_doorbell_frame #(.BASE_SPI(BASE), .NUM_SPI(NUM), .MODE(0), .ID_CODE(IDV)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_a), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rd_a), .ready(rdy_a), .irq_out(irq_a));
  msi_doorbell_frame #(.BASE_SPI(BASE), .NUM_SPI(NUM), .MODE(1), .FIXED_OFS(1), .ID_CODE(IDV)) dut_off (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_o), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rd_o), .ready(rdy_o), .irq_out(irq_o));
  msi_doorbell_frame #(.BASE_SPI(BASE), .NUM_SPI(NUM), .MODE(2), .ID_CODE(IDV)) dut_adr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_x), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rd_x), .ready(rdy_x), .irq_out(irq_x));

  localparam int NV = 8;
  localparam logic [31:0] V_DATA [NV] = '{32'd64, 32'd79, 32'd70, 32'd63,
                                          32'd80, 32'd0, 32'hFFFF_FFFF, 32'h0001_0040};
  localparam int V_EXP [NV] = '{0, 15, 6, -1, -1, -1, -1, -1};

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NUM-1:0] onehot(input int i);
    return (i < 0) ? '0 : (NUM'(1) << i);
  endfunction

  task automatic wr(input int which, input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    wr_a = (which == 0); wr_o = (which == 1); wr_x = (which == 2);
    @(negedge clk);
    wr_a = 0; wr_o = 0; wr_x = 0;
  endtask

  task automatic rd(input logic [12:0] a);
    @(negedge clk);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(32'(irq_a | irq_o | irq_x), 0, "R1 outputs low in reset");
    check(32'(rdy_a), 0, "R1 ready low");
    rst_n = 1;
    @(negedge clk);
    check(32'(irq_a), 0, "R1 outputs low after reset");
    rd(13'h010);
    check(rd_a, 0, "R1 fault clear");
    check(32'(rdy_a), 1, "R10 ready after read");
    @(negedge clk);
    check(32'(rdy_a), 0, "R10 ready one cycle only");

    rd(13'h008);
    check(rd_a, 32'h0040_0010, "R2 descriptor abs");
    check(rd_x, 32'h0040_0010, "R2 descriptor adr");
    rd(13'hFCC);
    check(rd_a, IDV, "R3 id register");
    rd(13'h004);
    check(rd_a, 0, "R9 unmapped 0x004");
    rd(13'hFC8);
    check(rd_a, 0, "R9 unmapped 0xFC8");

    wr(0, 13'h008, 32'hFFFF_FFFF);
    check(32'(irq_a), 0, "R9 descriptor write no pulse");
    wr(0, 13'hFCC, 32'h0);
    check(32'(irq_a), 0, "R9 id write no pulse");
    wr(0, 13'h010, 32'h1);
    check(32'(irq_a), 0, "R9 fault write no pulse");
    rd(13'h008);
    check(rd_a, 32'h0040_0010, "R9 descriptor unchanged");
    rd(13'hFCC);
    check(rd_a, IDV, "R9 id unchanged");
    rd(13'h010);
    check(rd_a, 0, "R9 fault unchanged");

    for (int i = 0; i < NV; i++) begin
      wr(0, 13'h040, V_DATA[i]);
      check(32'(irq_a), 32'(onehot(V_EXP[i])), (V_EXP[i] < 0) ? "R7 out of window" : "R4 absolute");
      if (i == 2) begin
        rd(13'h010);
        check(rd_a, 0, "R7 fault still clear");
      end
    end
    rd(13'h010);
    check(rd_a, 1, "R7 fault set abs");
    wr(0, 13'h040, 32'd65);
    rd(13'h010);
    check(rd_a, 1, "R7 fault sticky");

    @(negedge clk);
    addr = 13'h040; wdata = 32'd66; wr_a = 1;
    @(negedge clk);
    check(32'(irq_a), 32'h4, "R8 first pulse");
    @(negedge clk);
    wr_a = 0;
    check(32'(irq_a), 32'h4, "R8 second pulse");
    @(negedge clk);
    check(32'(irq_a), 0, "R8 line drops");

    wr(1, 13'h040, 32'd32);
    check(32'(irq_o), 32'h1, "R5 offset low edge");
    wr(1, 13'h040, 32'd47);
    check(32'(irq_o), 32'h8000, "R5 offset high edge");
    rd(13'h010);
    check(rd_o, 0, "R5 no fault yet");
    wr(1, 13'h040, 32'd48);
    check(32'(irq_o), 0, "R7 offset miss");
    rd(13'h010);
    check(rd_o, 1, "R7 offset fault");

    wr(2, 13'h100, 32'hDEAD_BEEF);
    check(32'(irq_x), 32'h1, "R6 address base");
    wr(2, 13'h138, 32'h0);
    check(32'(irq_x), 32'h80, "R6 address spi71");
    wr(2, 13'h101, 32'h0);
    check(32'(irq_x), 0, "R6 misaligned ignored");
    rd(13'h010);
    check(rd_x, 0, "R6 misaligned no fault");
    wr(2, 13'h180, 32'h0);
    check(32'(irq_x), 0, "R7 address above window");
    wr(2, 13'h0F8, 32'h0);
    check(32'(irq_x), 0, "R7 address below window");
    rd(13'h010);
    check(rd_x, 1, "R7 address fault");
    check(32'(irq_a | irq_o), 0, "R11 others idle");

    finish_run();
  end
endmodule